// File: doc/BRIEF.md
# Restoring Array Divider

This block divides one unsigned N-bit operand by another in a single combinational pass and returns both the quotient and the remainder. The hardware is a fully unrolled stack of N rows. Each row takes the partial remainder handed down from the row above, shifts it left one place and fills the freed low bit with the next dividend bit, starting from the most significant. It then subtracts the divisor with a ripple-borrow chain. The borrow that leaves the top of that chain tells whether the trial difference went negative. That one signal chooses, for every bit of the row, between the difference and the untouched partial remainder, and its inverse is the row's quotient bit.

The block has no clock and no storage. A surrounding pipeline registers its inputs and outputs as it needs. The width is a parameter with a default of 4 and is meant to be used at 8, 16 or more. The longest path runs through N borrow chains of about N cells each, so delay grows with the square of the width.

Top module: `arr_divider`

## Requirements
- R1: For every divisor other than zero, `quo` equals the integer quotient of `dvd` by `dvs` rounded toward zero, and `rem` equals the matching remainder.
- R2: Whenever `dvs` is not zero, `rem` is strictly less than `dvs`.
- R3: Whenever `dvs` is not zero, `quo * dvs + rem` computed at 2N bits equals `dvd`.
- R4: When `dvs` is zero, every bit of `quo` is 1 and `rem` equals `dvd`.
- R5: When `dvs` is not zero and `dvd` is less than `dvs`, `quo` is zero and `rem` equals `dvd`.
- R6: When `dvs` is 1, `quo` equals `dvd` and `rem` is zero.
- R7: When `dvd` equals `dvs` and neither is zero, `quo` is 1 and `rem` is zero.
- R8: The outputs depend only on the present operands. At N=4 every one of the 256 operand pairs gives the result stated in R1 to R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dvd | input | N | Unsigned dividend |
| dvs | input | N | Unsigned divisor |
| quo | output | N | Quotient; bit i comes from row i, where row N-1 is evaluated first |
| rem | output | N | Remainder left by the last row |

## Verification
Within each row the same negative signal makes two decisions at once: it sets the quotient bit, and it picks whether the partial remainder is restored or replaced by the difference. A fault in one of them would corrupt `quo` and `rem` in the same evaluation. Both outputs are therefore judged together against the division and modulo operators for every operand pair. Pairs that force one extreme of that choice in every row are driven on purpose: a zero divisor makes every row take the difference, and a dividend below the divisor makes every row restore. Those pairs confirm that each choice gives the quotient bit and the remainder the stated values together.

// File: rtl/arr_div_pkg.sv
package arr_div_pkg;

    typedef struct packed {
        logic diff;
        logic borrow;
    } sub_bit_t;

    // One-bit full subtractor: r - d - bin
    function automatic sub_bit_t full_sub(input logic r, input logic d, input logic bin);
        sub_bit_t s;
        s.diff   = r ^ d ^ bin;
        s.borrow = (~r & d) | (~(r ^ d) & bin);
        return s;
    endfunction

endpackage

// File: rtl/arr_div_cell.sv
module arr_div_cell
    import arr_div_pkg::*;
(
    input  logic r_bit,
    input  logic d_bit,
    input  logic bin,
    input  logic neg,
    output logic bout,
    output logic keep_bit
);

    sub_bit_t s;

    assign s        = full_sub(r_bit, d_bit, bin);
    assign bout     = s.borrow;
    // Restore the incoming bit when the row went negative
    assign keep_bit = neg ? r_bit : s.diff;

endmodule

// File: rtl/arr_div_row.sv
module arr_div_row #(
    parameter int N = 4
) (
    input  logic [N-1:0] rem_in,
    input  logic         a_bit,
    input  logic [N-1:0] divisor,
    output logic [N-1:0] rem_out,
    output logic         q_bit
);

    localparam int PW = N + 1;

    logic [PW-1:0] pr;
    logic [PW-1:0] bc;
    logic          neg;

    // Shifted partial remainder with the next dividend bit inserted
    assign pr    = {rem_in, a_bit};
    assign bc[0] = 1'b0;

    for (genvar k = 0; k < N; k++) begin : g_cell
        arr_div_cell u_cell (
            .r_bit    (pr[k]),
            .d_bit    (divisor[k]),
            .bin      (bc[k]),
            .neg      (neg),
            .bout     (bc[k+1]),
            .keep_bit (rem_out[k])
        );
    end

    // Leftmost position: divisor bit is zero, only the borrow matters
    assign neg   = ~pr[PW-1] & bc[N];
    assign q_bit = ~neg;

endmodule

// File: rtl/arr_divider.sv
module arr_divider #(
    parameter int N = 4
) (
    input  logic [N-1:0] dvd,
    input  logic [N-1:0] dvs,
    output logic [N-1:0] quo,
    output logic [N-1:0] rem
);

    localparam int ROWS = N;

    logic [N-1:0] prem [ROWS+1];

    assign prem[ROWS] = '0;

    // Row ROWS-1 handles the dividend MSB first
    for (genvar i = ROWS - 1; i >= 0; i--) begin : g_row
        arr_div_row #(.N(N)) u_row (
            .rem_in  (prem[i+1]),
            .a_bit   (dvd[i]),
            .divisor (dvs),
            .rem_out (prem[i]),
            .q_bit   (quo[i])
        );
    end

    assign rem = prem[0];

endmodule

// File: rtl/arr_divider_chk.sv
module arr_divider_chk #(
    parameter int N = 4
) (
    input logic [N-1:0] dvd,
    input logic [N-1:0] dvs,
    input logic [N-1:0] quo,
    input logic [N-1:0] rem
);

    localparam int W2 = 2 * N;

    logic [W2-1:0] recon;

    always_comb begin
        recon = W2'(quo) * W2'(dvs) + W2'(rem);
        if (dvs != '0) begin
            p_rem_below_div_r2: assert (rem < dvs);
            p_reconstruct_r3:   assert (recon == W2'(dvd));
        end
        if (dvs == '0) begin
            p_zero_div_r4: assert (quo == '1 && rem == dvd);
        end
        if (dvs != '0 && dvd < dvs) begin
            p_small_dvd_r5: assert (quo == '0 && rem == dvd);
        end
        if (dvs == N'(1)) begin
            p_unit_div_r6: assert (quo == dvd && rem == '0);
        end
        if (dvs != '0 && dvd == dvs) begin
            p_equal_ops_r7: assert (quo == N'(1) && rem == '0);
        end
    end

endmodule

bind arr_divider arr_divider_chk #(.N(N)) u_chk (
    .dvd (dvd),
    .dvs (dvs),
    .quo (quo),
    .rem (rem)
);

// File: tb/sim_arr_divider.sv
module sim_arr_divider;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [3:0]  a4, b4, q4, r4;
    logic [7:0]  a8, b8, q8, r8;
    logic [15:0] a16, b16, q16, r16;

    arr_divider #(.N(4))  u0 (.dvd(a4),  .dvs(b4),  .quo(q4),  .rem(r4));
    arr_divider #(.N(8))  u1 (.dvd(a8),  .dvs(b8),  .quo(q8),  .rem(r8));
    arr_divider #(.N(16)) u2 (.dvd(a16), .dvs(b16), .quo(q16), .rem(r16));

    // {dividend, divisor, quotient, remainder} at N=8
    localparam logic [31:0] VEC [10] = '{
        32'hC8_07_1C_04,
        32'hFF_FF_01_00,
        32'hFF_01_FF_00,
        32'h05_09_00_05,
        32'h00_03_00_00,
        32'h64_00_FF_64,
        32'h80_10_08_00,
        32'hFE_7F_02_00,
        32'hAD_0C_0E_05,
        32'h01_02_00_01
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic apply_step;
        @(negedge clk);
    endtask

    function automatic string tag_for(input int a, input int b);
        if (b == 0)      return "R4";
        else if (a < b)  return "R5";
        else if (b == 1) return "R6";
        else if (a == b) return "R7";
        else             return "R1";
    endfunction

    initial begin
        a4 = '0; b4 = '0; a8 = '0; b8 = '0; a16 = '0; b16 = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        apply_step();
        // Reset-time operands are zero/zero: R4 applies
        chk("R4 reset q", 32'(q4), 32'hF);
        chk("R4 reset r", 32'(r4), 32'h0);

        // Table walk at N=8
        for (int v = 0; v < 10; v++) begin
            @(posedge clk); #1;
            a8 = VEC[v][31:24];
            b8 = VEC[v][23:16];
            apply_step();
            chk({tag_for(int'(a8), int'(b8)), " table q"}, 32'(q8), 32'(VEC[v][15:8]));
            chk({tag_for(int'(a8), int'(b8)), " table r"}, 32'(r8), 32'(VEC[v][7:0]));
        end

        // R8: exhaustive sweep at N=4
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                @(posedge clk); #1;
                a4 = 4'(a);
                b4 = 4'(b);
                apply_step();
                if (b == 0) begin
                    chk("R8/R4 q", 32'(q4), 32'hF);
                    chk("R8/R4 r", 32'(r4), 32'(a));
                end else begin
                    chk({"R8/", tag_for(a, b), " q"}, 32'(q4), 32'(a / b));
                    chk({"R8/", tag_for(a, b), " r"}, 32'(r4), 32'(a % b));
                end
            end
        end

        // Random pairs at N=16, with R2 and R3 judged from ports
        for (int n = 0; n < 400; n++) begin
            logic [15:0] ra, rb;
            logic [31:0] rc;
            ra = 16'($urandom);
            rb = (n % 4 == 0) ? 16'($urandom_range(0, 20)) : 16'($urandom);
            @(posedge clk); #1;
            a16 = ra;
            b16 = rb;
            apply_step();
            if (rb == 16'd0) begin
                chk("R4 rand q", 32'(q16), 32'hFFFF);
                chk("R4 rand r", 32'(r16), 32'(ra));
            end else begin
                chk("R1 rand q", 32'(q16), 32'(ra / rb));
                chk("R1 rand r", 32'(r16), 32'(ra % rb));
                chk("R2 rem<div", 32'(r16 < rb), 32'd1);
                rc = 32'(q16) * 32'(rb) + 32'(r16);
                chk("R3 recon", rc, 32'(ra));
            end
        end

        // Directed corners at N=16
        @(posedge clk); #1; a16 = 16'hFFFF; b16 = 16'h0001; apply_step();
        chk("R6 q", 32'(q16), 32'hFFFF);
        chk("R6 r", 32'(r16), 32'h0);
        @(posedge clk); #1; a16 = 16'h8001; b16 = 16'h8001; apply_step();
        chk("R7 q", 32'(q16), 32'h1);
        chk("R7 r", 32'(r16), 32'h0);
        @(posedge clk); #1; a16 = 16'h1234; b16 = 16'h0000; apply_step();
        chk("R4 q", 32'(q16), 32'hFFFF);
        chk("R4 r", 32'(r16), 32'h1234);
        @(posedge clk); #1; a16 = 16'h7FFF; b16 = 16'h8000; apply_step();
        chk("R5 q", 32'(q16), 32'h0);
        chk("R5 r", 32'(r16), 32'h7FFF);
        @(posedge clk); #1; a8 = 8'hFF; b8 = 8'h80; apply_step();
        chk("R1 q top", 32'(q8), 32'h1);
        chk("R1 r top", 32'(r8), 32'h7F);

        if (!finished) begin
            finished = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule